// File: doc/BRIEF.md
# Programmable FIFO Word Packer

This block sits between a 32-bit FIFO and a serial protocol engine and converts between FIFO entries and protocol words. The mapping is not a fixed byte order. Up to four 10-bit packing vectors per direction describe it. Each vector lifts a field of one to eight bits out of the entry, starting at a chosen bit index and walking either downward or upward. A stop flag ends the list of vectors used for one entry. A granularity code decides how many vectors make up each protocol word.

On the transmit side, one accepted entry is unpacked into one or more protocol words, which are presented one after another. On the receive side, protocol words are scattered back into an entry. The entry is handed to the FIFO once the word that completes it arrives. Each direction has its own vector set and granularity, and both sides use valid/ready handshakes.

Top module: `fifo_word_packer`

## Requirements
- R1: After reset, `tx_word_valid` and `rx_fifo_valid` are low, and `tx_fifo_ready` and `rx_word_ready` are high.
- R2: Vector layout: bits [9:5] give the start index, bit 4 the direction, bits [3:1] the field length minus one, and bit 0 the stop flag. Vectors 0 and 1 sit in bits [9:0] and [19:10] of the first config port, and vectors 2 and 3 in the same places of the second port. With direction 1, the field's MSB is entry bit `start` and lower field bits come from lower entry bits.
- R3: With direction 0, the field's LSB is entry bit `start` and higher field bits come from higher entry bits.
- R4: Only vectors up to and including the lowest-numbered one with the stop flag set are used for an entry, and the next entry then begins. If no stop flag is set, all four vectors are used.
- R5: Granularity 0 makes each vector its own protocol word. Granularity 1 joins vectors {0,1} and {2,3} into one word each. Granularity 2 and 3 join all used vectors into one word. Words are emitted in order of their lowest vector.
- R6: Inside one word, a direction-1 field sits above the fields of the later vectors of that word, and a direction-0 field sits above the fields of the earlier vectors. Words are right-aligned, and unused upper bits are zero on transmit.
- R7: Field bits whose entry index falls outside 0..31 read as zero on transmit and are dropped on receive.
- R8: Receive packing is the inverse mapping. Entry bits that no used vector selects are zero, and nothing carries over from the previous entry. The entry becomes valid on the cycle after its last word is accepted.
- R9: `tx_word_valid` rises on the cycle after an entry is accepted. A stalled word holds its value. A new entry is accepted in the same cycle as the last word of the current one, so one-word entries stream at one word per cycle.
- R10: While a completed receive entry waits with `rx_fifo_ready` low, it holds its value and `rx_word_ready` stays low.
- R11: Transmit and receive configurations act independently when both sides run at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_pack_cfg0 | input | 20 | TX vectors 0 (low) and 1 (high) |
| tx_pack_cfg1 | input | 20 | TX vectors 2 (low) and 3 (high) |
| tx_gran | input | 2 | TX vectors-per-word code |
| rx_pack_cfg0 | input | 20 | RX vectors 0 and 1 |
| rx_pack_cfg1 | input | 20 | RX vectors 2 and 3 |
| rx_gran | input | 2 | RX vectors-per-word code |
| tx_fifo_data | input | 32 | Entry from the FIFO |
| tx_fifo_valid | input | 1 | Entry offered |
| tx_fifo_ready | output | 1 | Entry accepted |
| tx_word_data | output | 32 | Unpacked protocol word |
| tx_word_valid | output | 1 | Word offered |
| tx_word_ready | input | 1 | Word taken |
| rx_word_data | input | 32 | Received protocol word |
| rx_word_valid | input | 1 | Word offered |
| rx_word_ready | output | 1 | Word accepted |
| rx_fifo_data | output | 32 | Packed entry to the FIFO |
| rx_fifo_valid | output | 1 | Entry offered |
| rx_fifo_ready | input | 1 | Entry taken |

## Verification
A transmit word is due one cycle after its entry is accepted. Each further word of that entry follows on the next cycle in which the consumer is ready. A packed receive entry is due one cycle after the handshake on its final word. The bench drives inputs just after the rising edge and samples every handshake at the falling edge, so each comparison reads values that settled one full edge after their cause. It checks these latencies, the value held during a stall, and a back-to-back run of three transfers spanning exactly two cycles.

// File: rtl/fifo_word_packer.sv
module fifo_word_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [19:0] tx_pack_cfg0,
  input  logic [19:0] tx_pack_cfg1,
  input  logic [1:0]  tx_gran,
  input  logic [19:0] rx_pack_cfg0,
  input  logic [19:0] rx_pack_cfg1,
  input  logic [1:0]  rx_gran,
  input  logic [31:0] tx_fifo_data,
  input  logic        tx_fifo_valid,
  output logic        tx_fifo_ready,
  output logic [31:0] tx_word_data,
  output logic        tx_word_valid,
  input  logic        tx_word_ready,
  input  logic [31:0] rx_word_data,
  input  logic        rx_word_valid,
  output logic        rx_word_ready,
  output logic [31:0] rx_fifo_data,
  output logic        rx_fifo_valid,
  input  logic        rx_fifo_ready
);

  localparam int NVEC  = 4;
  localparam int VW    = 10;
  localparam int EW    = 32;
  localparam int SETW  = NVEC * VW;

  function automatic logic [1:0] last_vec(input logic [SETW-1:0] v);
    logic [1:0] r;
    r = 2'(NVEC - 1);
    for (int k = NVEC - 1; k >= 0; k--)
      if (v[k*VW]) r = 2'(k);
    return r;
  endfunction

  function automatic logic [1:0] grp(input logic [1:0] g, input int k);
    case (g)
      2'd0:    return 2'(k);
      2'd1:    return 2'(k >> 1);
      default: return 2'd0;
    endcase
  endfunction

  function automatic int place(input logic [SETW-1:0] v, input logic [1:0] g, input int k);
    int sum;
    logic [1:0] lv;
    sum = 0;
    lv = last_vec(v);
    for (int j = 0; j < NVEC; j++)
      if (j != k && j <= int'(lv) && grp(g, j) == grp(g, k))
        if (v[k*VW+4] ? (j > k) : (j < k))
          sum += int'(v[j*VW+1 +: 3]) + 1;
    return sum;
  endfunction

  function automatic logic [EW-1:0] unpack(input logic [EW-1:0] e, input logic [SETW-1:0] v,
                                           input logic [1:0] g, input logic [1:0] sel);
    logic [EW-1:0] w;
    logic [1:0] lv;
    int n, p, s, d;
    w = '0;
    lv = last_vec(v);
    for (int k = 0; k < NVEC; k++)
      if (k <= int'(lv) && grp(g, k) == sel) begin
        n = int'(v[k*VW+1 +: 3]);
        p = place(v, g, k);
        for (int i = 0; i < 8; i++)
          if (i <= n) begin
            s = v[k*VW+4] ? int'(v[k*VW+5 +: 5]) - i : int'(v[k*VW+5 +: 5]) + i;
            d = v[k*VW+4] ? p + n - i : p + i;
            if (s >= 0 && s < EW && d < EW) w[d[4:0]] = w[d[4:0]] | e[s[4:0]];
          end
      end
    return w;
  endfunction

  function automatic logic [EW-1:0] scatter(input logic [EW-1:0] w, input logic [SETW-1:0] v,
                                            input logic [1:0] g, input logic [1:0] sel);
    logic [EW-1:0] e;
    logic [1:0] lv;
    int n, p, s, d;
    e = '0;
    lv = last_vec(v);
    for (int k = 0; k < NVEC; k++)
      if (k <= int'(lv) && grp(g, k) == sel) begin
        n = int'(v[k*VW+1 +: 3]);
        p = place(v, g, k);
        for (int i = 0; i < 8; i++)
          if (i <= n) begin
            s = v[k*VW+4] ? int'(v[k*VW+5 +: 5]) - i : int'(v[k*VW+5 +: 5]) + i;
            d = v[k*VW+4] ? p + n - i : p + i;
            if (s >= 0 && s < EW && d < EW) e[s[4:0]] = e[s[4:0]] | w[d[4:0]];
          end
      end
    return e;
  endfunction

  logic [SETW-1:0] tx_vecs, rx_vecs;
  assign tx_vecs = {tx_pack_cfg1, tx_pack_cfg0};
  assign rx_vecs = {rx_pack_cfg1, rx_pack_cfg0};

  // transmit: hold one entry, walk its word groups
  logic [EW-1:0] tx_hold;
  logic          tx_busy;
  logic [1:0]    tx_cnt, tx_end_grp;
  logic          tx_done;

  assign tx_end_grp    = grp(tx_gran, int'(last_vec(tx_vecs)));
  assign tx_word_valid = tx_busy;
  assign tx_word_data  = unpack(tx_hold, tx_vecs, tx_gran, tx_cnt);
  assign tx_done       = tx_busy && tx_word_ready && tx_cnt == tx_end_grp;
  assign tx_fifo_ready = !tx_busy || tx_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_cnt  <= '0;
      tx_hold <= '0;
    end else if (tx_fifo_valid && tx_fifo_ready) begin
      tx_hold <= tx_fifo_data;
      tx_busy <= 1'b1;
      tx_cnt  <= '0;
    end else if (tx_done) begin
      tx_busy <= 1'b0;
      tx_cnt  <= '0;
    end else if (tx_busy && tx_word_ready) begin
      tx_cnt <= tx_cnt + 2'd1;
    end
  end

  // receive: merge word groups, publish on the last one
  logic [EW-1:0] rx_acc, rx_merged;
  logic [1:0]    rx_cnt, rx_end_grp;
  logic          rx_take, rx_end;

  assign rx_end_grp    = grp(rx_gran, int'(last_vec(rx_vecs)));
  assign rx_word_ready = !rx_fifo_valid || rx_fifo_ready;
  assign rx_take       = rx_word_valid && rx_word_ready;
  assign rx_end        = rx_cnt == rx_end_grp;
  assign rx_merged     = (rx_cnt == 2'd0 ? '0 : rx_acc) |
                         scatter(rx_word_data, rx_vecs, rx_gran, rx_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_acc        <= '0;
      rx_cnt        <= '0;
      rx_fifo_data  <= '0;
      rx_fifo_valid <= 1'b0;
    end else begin
      if (rx_take && rx_end) begin
        rx_fifo_data  <= rx_merged;
        rx_fifo_valid <= 1'b1;
        rx_cnt        <= '0;
      end else begin
        if (rx_fifo_ready) rx_fifo_valid <= 1'b0;
        if (rx_take) begin
          rx_acc <= rx_merged;
          rx_cnt <= rx_cnt + 2'd1;
        end
      end
    end
  end

  assert_tx_word_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_word_valid && !tx_word_ready |=> tx_word_valid && $stable(tx_word_data));

  assert_tx_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fifo_valid && tx_fifo_ready |=> tx_word_valid);

  assert_rx_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_valid && !rx_fifo_ready |=> rx_fifo_valid && $stable(rx_fifo_data));

  assert_rx_out_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_fifo_valid) |-> $past(rx_word_valid && rx_word_ready));

endmodule

// File: tb/tb_fifo_word_packer.sv
module tb_fifo_word_packer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [19:0] tx_pack_cfg0 = '0, tx_pack_cfg1 = '0, rx_pack_cfg0 = '0, rx_pack_cfg1 = '0;
  logic [1:0]  tx_gran = '0, rx_gran = '0;
  logic [31:0] tx_fifo_data = '0, rx_word_data = '0;
  logic        tx_fifo_valid = 1'b0, rx_word_valid = 1'b0, tx_word_ready = 1'b0;
  logic        rx_fifo_ready = 1'b1;
  logic        tx_fifo_ready, tx_word_valid, rx_word_ready, rx_fifo_valid;
  logic [31:0] tx_word_data, rx_fifo_data;

  fifo_word_packer dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit bp = 0, rx_is_last = 0;
  logic [31:0] tx_exp[$], rx_exp[$];
  string tx_tag[$], rx_tag[$];
  int tx_cyc[$];

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] mkvec(int start, bit dir, int len, bit stop);
    return {5'(start), dir, 3'(len - 1), stop};
  endfunction

  task automatic set_tx(logic [9:0] v0, v1, v2, v3, logic [1:0] g);
    tx_pack_cfg0 = {v1, v0}; tx_pack_cfg1 = {v3, v2}; tx_gran = g;
  endtask
  task automatic set_rx(logic [9:0] v0, v1, v2, v3, logic [1:0] g);
    rx_pack_cfg0 = {v1, v0}; rx_pack_cfg1 = {v3, v2}; rx_gran = g;
  endtask

  task automatic exp_tx(logic [31:0] v, string t); tx_exp.push_back(v); tx_tag.push_back(t); endtask
  task automatic exp_rx(logic [31:0] v, string t); rx_exp.push_back(v); rx_tag.push_back(t); endtask

  task automatic tx_push(logic [31:0] d);
    tx_fifo_data = d; tx_fifo_valid = 1'b1;
    do @(negedge clk); while (!tx_fifo_ready);
    @(posedge clk); #1;
    tx_fifo_valid = 1'b0;
  endtask

  task automatic rx_push(logic [31:0] w, bit last);
    rx_word_data = w; rx_word_valid = 1'b1; rx_is_last = last;
    do @(negedge clk); while (!rx_word_ready);
    @(posedge clk); #1;
    rx_word_valid = 1'b0; rx_is_last = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && (tx_exp.size() != 0 || rx_exp.size() != 0); i++) @(negedge clk);
    check(tx_exp.size() == 0 && rx_exp.size() == 0, "all expected items delivered",
          32'(tx_exp.size() + rx_exp.size()), 0);
    repeat (2) @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 tx_word_ready = bp ? (cyc % 3 != 0) : 1'b1;
  end

  bit tx_prev_stall = 0, tx_prev_in = 0, rx_prev_last = 0;
  logic [31:0] tx_prev_data = '0, exp_v;
  string exp_t;

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_prev_stall)
        check(tx_word_valid && tx_word_data == tx_prev_data, "R9 stalled word held", tx_word_data, tx_prev_data);
      if (tx_prev_in)
        check(tx_word_valid, "R9 word valid one cycle after entry", 32'(tx_word_valid), 1);
      if (tx_word_valid && tx_word_ready) begin
        tx_cyc.push_back(cyc);
        if (tx_exp.size() == 0) check(0, "unexpected tx word", tx_word_data, 0);
        else begin
          exp_v = tx_exp.pop_front(); exp_t = tx_tag.pop_front();
          check(tx_word_data == exp_v, exp_t, tx_word_data, exp_v);
        end
      end
      tx_prev_stall = tx_word_valid && !tx_word_ready;
      tx_prev_data  = tx_word_data;
      tx_prev_in    = tx_fifo_valid && tx_fifo_ready;

      if (rx_prev_last)
        check(rx_fifo_valid, "R8 entry valid one cycle after last word", 32'(rx_fifo_valid), 1);
      if (rx_fifo_valid && !rx_fifo_ready)
        check(!rx_word_ready, "R10 words blocked while entry waits", 32'(rx_word_ready), 0);
      if (rx_fifo_valid && rx_fifo_ready) begin
        if (rx_exp.size() == 0) check(0, "unexpected rx entry", rx_fifo_data, 0);
        else begin
          exp_v = rx_exp.pop_front(); exp_t = rx_tag.pop_front();
          check(rx_fifo_data == exp_v, exp_t, rx_fifo_data, exp_v);
        end
      end
      rx_prev_last = rx_word_valid && rx_word_ready && rx_is_last;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!tx_word_valid && !rx_fifo_valid && tx_fifo_ready && rx_word_ready, "R1 reset state",
          {tx_word_valid, rx_fifo_valid, tx_fifo_ready, rx_word_ready}, 32'h3);
    @(posedge clk); #1;

    // R2 R5: byte vectors MSB-first, granularity 0
    set_tx(mkvec(7,1,8,0), mkvec(15,1,8,0), mkvec(23,1,8,0), mkvec(31,1,8,1), 2'd0);
    exp_tx(32'hD4, "R2 R5 byte0"); exp_tx(32'hC3, "R2 R5 byte1");
    exp_tx(32'hB2, "R2 R5 byte2"); exp_tx(32'hA1, "R2 R5 byte3");
    tx_push(32'hA1B2C3D4); drain();

    // R3 upward field vs R2 downward field
    set_tx(mkvec(4,0,4,1), '0, '0, '0, 2'd0);
    exp_tx(32'hD, "R3 upward nibble"); tx_push(32'hA1B2C3D4); drain();
    set_tx(mkvec(4,1,4,1), '0, '0, '0, 2'd0);
    exp_tx(32'hA, "R2 downward nibble"); tx_push(32'hA1B2C3D4); drain();

    // R4 stop mid-list
    set_tx(mkvec(7,1,8,0), mkvec(15,1,8,1), mkvec(23,1,8,0), mkvec(31,1,8,1), 2'd0);
    exp_tx(32'hD4, "R4 stop e0 w0"); exp_tx(32'hC3, "R4 stop e0 w1");
    exp_tx(32'h44, "R4 stop e1 w0"); exp_tx(32'h33, "R4 stop e1 w1");
    tx_push(32'hA1B2C3D4); tx_push(32'h11223344); drain();

    // R5 R6 granularity 1, both directions
    set_tx(mkvec(15,1,8,0), mkvec(7,1,8,0), mkvec(31,1,8,0), mkvec(23,1,8,1), 2'd1);
    exp_tx(32'hC3D4, "R6 msb-first pair0"); exp_tx(32'hA1B2, "R6 msb-first pair1");
    tx_push(32'hA1B2C3D4); drain();
    set_tx(mkvec(8,0,8,0), mkvec(0,0,8,0), mkvec(16,0,8,0), mkvec(24,0,8,1), 2'd1);
    exp_tx(32'hD4C3, "R6 lsb-first pair0"); exp_tx(32'hA1B2, "R5 lsb-first pair1");
    tx_push(32'hA1B2C3D4); drain();

    // R5 12-bit word, granularity 2 and 3
    set_tx(mkvec(11,1,8,0), mkvec(3,1,4,1), '0, '0, 2'd2);
    exp_tx(32'hABC, "R5 12-bit gran2"); tx_push(32'hFFFFFABC); drain();
    tx_gran = 2'd3;
    exp_tx(32'hABC, "R5 12-bit gran3"); tx_push(32'h00000ABC); drain();

    // R4 no stop flag, R9 back-to-back streaming
    set_tx(mkvec(31,1,8,0), mkvec(23,1,8,0), mkvec(15,1,8,0), mkvec(7,1,8,0), 2'd2);
    tx_cyc.delete();
    exp_tx(32'h0F1E2D3C, "R4 all four vectors a"); exp_tx(32'h12345678, "R4 all four vectors b");
    exp_tx(32'hCAFEF00D, "R4 all four vectors c");
    tx_push(32'h0F1E2D3C); tx_push(32'h12345678); tx_push(32'hCAFEF00D); drain();
    check(tx_cyc.size() == 3 && tx_cyc[2] - tx_cyc[0] == 2, "R9 back-to-back span",
          32'(tx_cyc.size() == 3 ? tx_cyc[2] - tx_cyc[0] : -1), 2);

    // R7 out-of-range bits
    set_tx(mkvec(2,1,8,1), '0, '0, '0, 2'd0);
    exp_tx(32'hE0, "R7 below zero"); tx_push(32'hFFFFFFFF); drain();
    set_tx(mkvec(28,0,8,1), '0, '0, '0, 2'd0);
    exp_tx(32'h0F, "R7 above 31"); tx_push(32'hFFFFFFFF); drain();

    // R9 backpressure
    set_tx(mkvec(7,1,8,0), mkvec(15,1,8,0), mkvec(23,1,8,0), mkvec(31,1,8,1), 2'd0);
    bp = 1;
    exp_tx(32'h44, "R9 bp w0"); exp_tx(32'h33, "R9 bp w1"); exp_tx(32'h22, "R9 bp w2");
    exp_tx(32'h11, "R9 bp w3"); exp_tx(32'hEF, "R9 bp w4"); exp_tx(32'hBE, "R9 bp w5");
    exp_tx(32'hAD, "R9 bp w6"); exp_tx(32'hDE, "R9 bp w7");
    tx_push(32'h11223344); tx_push(32'hDEADBEEF); drain();
    bp = 0;

    // R8 receive packing
    set_rx(mkvec(7,1,8,0), mkvec(15,1,8,0), mkvec(23,1,8,0), mkvec(31,1,8,1), 2'd0);
    exp_rx(32'hA1B2C3D4, "R8 bytes packed");
    rx_push(32'hD4, 0); rx_push(32'hC3, 0); rx_push(32'hB2, 0); rx_push(32'hA1, 1); drain();
    set_rx(mkvec(11,1,8,0), mkvec(3,1,4,1), '0, '0, 2'd2);
    exp_rx(32'h00000ABC, "R8 unselected bits zero"); rx_push(32'hFFFFFABC, 1); drain();
    set_rx(mkvec(8,0,8,0), mkvec(0,0,8,0), mkvec(16,0,8,0), mkvec(24,0,8,1), 2'd1);
    exp_rx(32'hA1B2C3D4, "R6 rx lsb-first pairs");
    rx_push(32'hD4C3, 0); rx_push(32'hA1B2, 1); drain();
    set_rx(mkvec(2,1,8,1), '0, '0, '0, 2'd0);
    exp_rx(32'h00000007, "R7 rx dropped below zero"); rx_push(32'hFF, 1); drain();
    set_rx(mkvec(28,0,8,1), '0, '0, '0, 2'd0);
    exp_rx(32'hF0000000, "R7 rx dropped above 31"); rx_push(32'hFF, 1); drain();

    // R10 receive backpressure
    set_rx(mkvec(11,1,8,0), mkvec(3,1,4,1), '0, '0, 2'd2);
    rx_fifo_ready = 1'b0;
    exp_rx(32'h00000ABC, "R10 held entry a"); exp_rx(32'h00000123, "R10 entry b");
    fork
      begin rx_push(32'h0000FABC, 1); rx_push(32'h00000123, 1); end
      begin
        repeat (6) @(negedge clk);
        check(rx_fifo_valid && rx_fifo_data == 32'hABC && !rx_word_ready, "R10 entry held while blocked",
              rx_fifo_data, 32'hABC);
        @(posedge clk); #1 rx_fifo_ready = 1'b1;
      end
    join
    drain();

    // R11 independent directions at once
    set_tx(mkvec(7,1,8,0), mkvec(15,1,8,0), mkvec(23,1,8,0), mkvec(31,1,8,1), 2'd0);
    exp_tx(32'h04, "R11 tx w0"); exp_tx(32'h03, "R11 tx w1");
    exp_tx(32'h02, "R11 tx w2"); exp_tx(32'h01, "R11 tx w3");
    exp_rx(32'h00000456, "R11 rx entry");
    fork
      tx_push(32'h01020304);
      rx_push(32'hFFFFF456, 1);
    join
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule